// File: doc/BRIEF.md
# Six-pin bidirectional GPIO port

This block is a six-pin general-purpose I/O port that software controls through three byte-wide registers on a simple register bus. An output-value register holds the level each output pin drives, and a direction register chooses, pin by pin, whether the pin drives or listens. A read-only pin-state register returns the pad levels after a two-flop synchronizer. Reads are combinational from the address. Writes take effect on the clock edge where the write strobe is sampled high.

For every pin the block drives three pad controls: output enable, output value and pull-up enable. Pins 0 to 4 are push-pull. They drive when their direction bit is set. When they are inputs and their value bit is set, their pull-up turns on. Pin 5 works only as an open-drain pull-down. It never drives high and never has a pull-up. When it is set as an output, it pulls the line low if its value bit is zero and releases the line otherwise.

Reads of the output-value and direction registers return the stored bits and never the pad levels. Software can therefore change one pin by reading a register, changing one bit and writing it back, and the other pins keep their settings.

Top module: `gpio6_port`

## Requirements
- R1: After reset, the output-value register (offset 0x18) and the direction register (offset 0x17) read 0x00, and pad_oe and pad_pu are all zero.
- R2: A write to 0x18 or 0x17 stores bits 5:0 of the write data. A read of that offset returns the stored bits on bits 5:0, with bits 7:6 read as zero.
- R3: A read of offset 0x16 returns pad_in on bits 5:0, with bits 7:6 zero. A change on pad_in first shows up after the second rising clock edge that follows it.
- R4: A write to offset 0x16, or to any offset other than 0x17 and 0x18, changes neither stored register.
- R5: For pins 0 to 4, pad_oe[i] equals direction bit i and pad_out[i] equals value bit i.
- R6: For pins 0 to 4, pad_pu[i] is 1 exactly when direction bit i is 0 and value bit i is 1, so a pin never drives and pulls up at once.
- R7: Pin 5 has pad_out[5] = 0 and pad_pu[5] = 0 at all times. pad_oe[5] is 1 exactly when direction bit 5 is 1 and value bit 5 is 0.
- R8: A read of 0x18 or 0x17 returns the stored bits whatever the pad levels are. Writing back a read value with one bit changed leaves every other pin's controls unchanged.
- R9: A read of any offset other than 0x16, 0x17 and 0x18 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset for reads and writes |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pad_in | input | 6 | Pad input levels, asynchronous |
| pad_oe | output | 6 | Per-pin output enable |
| pad_out | output | 6 | Per-pin output value |
| pad_pu | output | 6 | Per-pin pull-up enable |

## Verification
The assertions assume that bus_addr, bus_wr and bus_wdata are stable around each rising edge. They also assume that any change on pad_in is followed by at least two quiet edges before the pin-state register is relied on. The stimulus changes every input one time unit after a rising edge and holds pad_in across every synchronizer latency check. Each write strobe lasts exactly one cycle, so each sampled edge captures one intended write.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    parameter int PORT_W = 6;
    parameter int DATA_W = 8;
    parameter int ADDR_W = 8;
    parameter int OD_PIN = PORT_W - 1;

    localparam logic [ADDR_W-1:0] OFS_PIN = ADDR_W'('h16);
    localparam logic [ADDR_W-1:0] OFS_DIR = ADDR_W'('h17);
    localparam logic [ADDR_W-1:0] OFS_DAT = ADDR_W'('h18);

    typedef logic [PORT_W-1:0] pins_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_PIN,
        SEL_DIR,
        SEL_DAT
    } reg_sel_e;

    typedef struct packed {
        pins_t oe;
        pins_t drv;
        pins_t pu;
    } pad_ctl_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_PIN: s = SEL_PIN;
            OFS_DIR: s = SEL_DIR;
            OFS_DAT: s = SEL_DAT;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] widen(input pins_t v);
        return {{(DATA_W-PORT_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  reg_sel_e sel,
    input  pins_t    wdata,
    output pins_t    data_q,
    output pins_t    dir_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dir_q  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_DAT: data_q <= wdata;
                SEL_DIR: dir_q  <= wdata;
                default: ;
            endcase
        end
    end

    // R2
    dat_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_DAT) |=> (data_q == $past(wdata)));

    // R2
    dir_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_DIR) |=> (dir_q == $past(wdata)));

    // R4
    ro_write_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_PIN || sel == SEL_NONE || !wr_en) |=> ($stable(data_q) && $stable(dir_q)));

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync
    import gpio_port_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pins_t pad_in,
    output pins_t pins_q
);

    pins_t stage1_q;
    logic  live_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            pins_q   <= '0;
            live_q   <= 1'b0;
        end else begin
            stage1_q <= pad_in;
            pins_q   <= stage1_q;
            live_q   <= 1'b1;
        end
    end

    // R3
    sync_first_chk: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (stage1_q == $past(pad_in)));

    // R3
    sync_second_chk: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (pins_q == $past(stage1_q)));

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
    import gpio_port_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pins_t    data_q,
    input  pins_t    dir_q,
    output pad_ctl_t ctl
);

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        if (i == OD_PIN) begin : g_open_drain
            always_comb begin
                ctl.oe[i]  = dir_q[i] & ~data_q[i];
                ctl.drv[i] = 1'b0;
                ctl.pu[i]  = 1'b0;
            end
        end else begin : g_push_pull
            always_comb begin
                ctl.oe[i]  = dir_q[i];
                ctl.drv[i] = data_q[i];
                ctl.pu[i]  = ~dir_q[i] & data_q[i];
            end
        end
    end

    // R6
    no_drive_pull_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.oe & ctl.pu) == '0);

    // R7
    od_never_high_chk: assert property (@(posedge clk) disable iff (rst)
        !(ctl.oe[OD_PIN] && ctl.drv[OD_PIN]));

endmodule

// File: rtl/gpio6_port.sv
module gpio6_port
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_pu
);

    reg_sel_e sel;
    pins_t    data_q;
    pins_t    dir_q;
    pins_t    pins_q;
    pad_ctl_t ctl;
    logic     unused_wbits;

    assign sel          = decode_addr(bus_addr);
    assign unused_wbits = ^bus_wdata[DATA_W-1:PORT_W];

    gpio_port_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (bus_wr),
        .sel    (sel),
        .wdata  (bus_wdata[PORT_W-1:0]),
        .data_q (data_q),
        .dir_q  (dir_q)
    );

    gpio_pin_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .pad_in (pad_in),
        .pins_q (pins_q)
    );

    gpio_pad_drive u_drive (
        .clk    (clk),
        .rst    (rst),
        .data_q (data_q),
        .dir_q  (dir_q),
        .ctl    (ctl)
    );

    always_comb begin
        case (sel)
            SEL_PIN: bus_rdata = widen(pins_q);
            SEL_DIR: bus_rdata = widen(dir_q);
            SEL_DAT: bus_rdata = widen(data_q);
            default: bus_rdata = '0;
        endcase
    end

    assign pad_oe  = ctl.oe;
    assign pad_out = ctl.drv;
    assign pad_pu  = ctl.pu;

    // R7
    od_pull_low_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_DAT && !bus_wdata[OD_PIN] && dir_q[OD_PIN])
        |=> (pad_oe[OD_PIN] && !pad_out[OD_PIN]));

    // R7
    od_no_pull_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_DAT && bus_wdata[OD_PIN]) |=> !pad_pu[OD_PIN]);

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE) |-> (bus_rdata == '0));

endmodule

// File: tb/gpio6_port_tb_top.sv
module gpio6_port_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [5:0] pad_in = '0;
    logic [5:0] pad_oe;
    logic [5:0] pad_out;
    logic [5:0] pad_pu;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int         kind_q[$];
    logic [7:0] exp_q[$];
    string      req_q[$];

    logic [5:0] sh_dat = '0;
    logic [5:0] sh_dir = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio6_port dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out),
        .pad_pu    (pad_pu)
    );

    function automatic logic [5:0] m_oe(input logic [5:0] dir, input logic [5:0] dat);
        return {dir[5] & ~dat[5], dir[4:0]};
    endfunction

    function automatic logic [5:0] m_out(input logic [5:0] dat);
        return {1'b0, dat[4:0]};
    endfunction

    function automatic logic [5:0] m_pu(input logic [5:0] dir, input logic [5:0] dat);
        return {1'b0, ~dir[4:0] & dat[4:0]};
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [7:0] v);
        @(posedge clk); #1;
        bus_addr  = a;
        bus_wdata = v;
        bus_wr    = 1'b1;
        if (a == 8'h18) sh_dat = v[5:0];
        if (a == 8'h17) sh_dir = v[5:0];
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic expect_read(input logic [7:0] a, input logic [7:0] e, input string req);
        @(posedge clk); #1;
        bus_addr = a;
        kind_q.push_back(0); exp_q.push_back(e); req_q.push_back(req);
    endtask

    task automatic expect_pads(input string req);
        @(posedge clk); #1;
        kind_q.push_back(1); exp_q.push_back({2'b0, m_oe(sh_dir, sh_dat)}); req_q.push_back(req);
        kind_q.push_back(2); exp_q.push_back({2'b0, m_out(sh_dat)}); req_q.push_back(req);
        kind_q.push_back(3); exp_q.push_back({2'b0, m_pu(sh_dir, sh_dat)}); req_q.push_back(req);
    endtask

    task automatic set_pins(input logic [5:0] v);
        @(posedge clk); #1;
        pad_in = v;
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            while (kind_q.size() > 0) begin
                int         k;
                logic [7:0] e;
                logic [7:0] act;
                string      r;
                string      nm;
                k = kind_q.pop_front();
                e = exp_q.pop_front();
                r = req_q.pop_front();
                case (k)
                    0: begin act = bus_rdata; nm = "rdata"; end
                    1: begin act = {2'b0, pad_oe}; nm = "pad_oe"; end
                    2: begin act = {2'b0, pad_out}; nm = "pad_out"; end
                    default: begin act = {2'b0, pad_pu}; nm = "pad_pu"; end
                endcase
                n_cmp++;
                if (act !== e) begin
                    n_bad++;
                    $display("FAIL %s %s: actual %h expected %h", r, nm, act, e);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        expect_read(8'h18, 8'h00, "R1");
        expect_read(8'h17, 8'h00, "R1");
        expect_pads("R1");

        // R2 storage, upper bits read zero; R6 pull-ups with all inputs
        bus_write(8'h18, 8'hFF);
        expect_read(8'h18, 8'h3F, "R2");
        expect_pads("R6");

        // R5 R7 all outputs, pin 5 released because its value is 1
        bus_write(8'h17, 8'hFF);
        expect_read(8'h17, 8'h3F, "R2");
        expect_pads("R5");

        // R7 pin 5 pulls low when value bit 5 is 0
        bus_write(8'h18, 8'h0A);
        expect_pads("R7");

        // R6 mixed directions
        bus_write(8'h17, 8'h15);
        expect_pads("R6");

        // R4 write to pin-state offset and to an unmapped offset
        bus_write(8'h16, 8'hFF);
        expect_read(8'h18, 8'h0A, "R4");
        expect_read(8'h17, 8'h15, "R4");
        bus_write(8'h10, 8'h00);
        expect_read(8'h18, 8'h0A, "R4");
        expect_read(8'h17, 8'h15, "R4");
        expect_pads("R4");

        // R9 unmapped read
        expect_read(8'h10, 8'h00, "R9");
        expect_read(8'h19, 8'h00, "R9");

        // R3 synchronizer latency
        set_pins(6'h2D);
        expect_read(8'h16, 8'h00, "R3");
        expect_read(8'h16, 8'h2D, "R3");
        set_pins(6'h3F);
        expect_read(8'h16, 8'h2D, "R3");
        expect_read(8'h16, 8'h3F, "R3");

        // R8 stored value read back regardless of pads, single-bit updates
        bus_write(8'h17, 8'h3F);
        bus_write(8'h18, 8'h0A);
        set_pins(6'h00);
        repeat (2) @(posedge clk);
        expect_read(8'h18, 8'h0A, "R8");
        expect_read(8'h17, 8'h3F, "R8");
        bus_write(8'h18, 8'h0A | 8'h04);
        expect_read(8'h18, 8'h0E, "R8");
        expect_pads("R8");
        bus_write(8'h17, 8'h3F & ~8'h02);
        expect_read(8'h17, 8'h3D, "R8");
        expect_pads("R8");
        bus_write(8'h18, 8'h0E | 8'h20);
        expect_pads("R7");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule